// File: doc/BRIEF.md
# NAND Bus Cycle Gap Guard

The guard sits between a NAND command sequencer and an asynchronous flash pin driver. The sequencer offers one bus cycle at a time over a valid/ready handshake, tagged as a command, an address, a data-in write or a status read. The guard turns each accepted request into a write or read strobe of fixed low and high widths, and drives the command-latch and address-latch enables. It runs only one bus cycle at a time.

Two minimum gaps depend on the interface mode. The first is the address-to-data gap, which starts at the write strobe rising edge of an address cycle that the sequencer flagged as the last one. The second is the write-to-read turnaround, which starts at the write strobe rising edge of any write-type cycle. Each gap has its own down-counter. A counter is loaded when its starting edge occurs, and it withholds the grant only from the request type that the gap protects. The minimum times come from a built-in mode table. A safety margin, in sixteenths, is added to each time before it is rounded up to core clock cycles. A status output names the gap that is currently holding off a waiting request.

Top module: `nand_gap_guard`

## Requirements
- R1: After a synchronous reset the write and read strobes are high (inactive), both latch enables are low, `stall_code` is 0 and `req_ready` is high.
- R2: The request kind encoding is 0 command, 1 address, 2 data-in, 3 status read. A request with kind 0, 1 or 2 drives `wr_strobe_n` low for STB_LO cycles and then high for at least STB_HI cycles. `cmd_latch` is high for the whole of a command cycle, `addr_latch` is high for the whole of an address cycle, and the two are never high together.
- R3: A status read drives `rd_strobe_n` low for STB_LO cycles while `wr_strobe_n` stays high. `req_ready` is high only while no bus cycle is in flight. Both strobes are never low together.
- R4: A gap limit in cycles is ceil(T × (16 + margin) / 16 / clock period). The times T are as follows. Address-to-data: 200 ns in mode 0, 150 ns in mode 1, 100 ns in mode 2. Turnaround: 120 ns in mode 0, 60 ns in mode 1, 80 ns in mode 2.
- R5: Take a data-in cycle that follows an address cycle with `req_last_addr` set. Its write strobe rising edge comes at least N_adl cycles after the address rising edge. If the data request is waiting, the gap is exactly max(N_adl, STB_LO+STB_HI+1).
- R6: The address-to-data gap is not armed by an address without the last flag. A later command or address cycle clears it. It does not delay status reads.
- R7: The first falling edge of `rd_strobe_n` comes at least N_whr cycles after the latest write strobe rising edge. If the read is waiting, the gap is exactly max(N_whr, STB_HI+1).
- R8: Command and address cycles are never stalled by either gap. Back-to-back write cycles are STB_LO+STB_HI+1 cycles apart, rising edge to rising edge.
- R9: `mode_sel` and `margin` are sampled only while the bus is idle. A gap counter that is already loaded keeps the limit that was in force when it was loaded.
- R10: `stall_code` is 1 while a waiting data-in request is held by the address-to-data gap, 2 while a waiting read is held by the turnaround, and 0 otherwise. A nonzero code implies `req_ready` is low.
- R11: Mode select 3 uses the same limits as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Sequencer offers a bus cycle |
| req_ready | output | 1 | Bus cycle accepted on this edge when valid |
| req_kind | input | 2 | 0 command, 1 address, 2 data-in, 3 status read |
| req_last_addr | input | 1 | Address cycle is the final one of its group |
| mode_sel | input | 2 | Interface timing mode (0, 1, 2; 3 behaves as 0) |
| margin | input | 4 | Safety margin in sixteenths of each limit |
| wr_strobe_n | output | 1 | Active-low write strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |
| cmd_latch | output | 1 | Command latch enable |
| addr_latch | output | 1 | Address latch enable |
| stall_code | output | 2 | 0 none, 1 address-to-data gap, 2 turnaround |

## Verification
A gap counter loaded with the wrong value, or one that misses a load or a clear, moves a strobe edge. That fault shows up on the next data strobe rising edge or on the next read strobe falling edge, and the edge distance is off by the counter error. If the mode latch samples at the wrong time, the next gap takes the wrong mode's length. If the strobe sequencer has an off-by-one error, the low width is wrong on the very first bus cycle after reset. The bench times every edge distance against limits it computes itself, across all modes and margins.

// File: rtl/nand_gap_pkg.sv
package nand_gap_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DIN  = 2'd2,
    K_STAT = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } strobe_phase_e;

  localparam int MODE_W   = 2;
  localparam int MARGIN_W = 4;
  localparam int TAB_SIZE = 1 << (MODE_W + MARGIN_W);

  // minimum address-to-data time per mode, nanoseconds
  function automatic int adl_min_ns(input int mode);
    case (mode)
      1:       return 150;
      2:       return 100;
      default: return 200;
    endcase
  endfunction

  // minimum write-to-read turnaround per mode, nanoseconds
  function automatic int whr_min_ns(input int mode);
    case (mode)
      1:       return 60;
      2:       return 80;
      default: return 120;
    endcase
  endfunction

  // stretch by margin/16, then round up to whole clock cycles
  function automatic int to_cycles(input int ns, input int mrg, input int clk_ps);
    int num;
    int den;
    num = ns * 1000 * (16 + mrg);
    den = 16 * clk_ps;
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/nand_gap_limits.sv
module nand_gap_limits
  import nand_gap_pkg::*;
#(
  parameter int CLK_PS = 10000,
  parameter int CNT_W  = 10
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [MARGIN_W-1:0] mrg,
  output logic [CNT_W-1:0]    adl_cyc,
  output logic [CNT_W-1:0]    whr_cyc
);

  localparam int NUM_MODES   = 1 << MODE_W;
  localparam int NUM_MARGINS = 1 << MARGIN_W;

  logic [CNT_W-1:0] adl_tab [TAB_SIZE];
  logic [CNT_W-1:0] whr_tab [TAB_SIZE];

  for (genvar gm = 0; gm < NUM_MODES; gm++) begin : g_mode
    for (genvar gg = 0; gg < NUM_MARGINS; gg++) begin : g_mrg
      assign adl_tab[gm*NUM_MARGINS+gg] = CNT_W'(to_cycles(adl_min_ns(gm), gg, CLK_PS));
      assign whr_tab[gm*NUM_MARGINS+gg] = CNT_W'(to_cycles(whr_min_ns(gm), gg, CLK_PS));
    end
  end

  assign adl_cyc = adl_tab[{mode, mrg}];
  assign whr_cyc = whr_tab[{mode, mrg}];

endmodule

// File: rtl/nand_gap_timer.sv
module nand_gap_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_gap_pkg::*;
#(
  parameter int STB_LO = 2,
  parameter int STB_HI = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      acc,
  input  bus_kind_e acc_kind,
  input  logic      acc_last,
  output logic      idle,
  output logic      wr_rise,
  output logic      adl_arm,
  output logic      wr_strobe_n,
  output logic      rd_strobe_n,
  output logic      cmd_latch,
  output logic      addr_latch
);

  localparam int MAXW = (STB_LO > STB_HI) ? STB_LO : STB_HI;
  localparam int SW   = $clog2(MAXW + 1);

  strobe_phase_e phase;
  logic [SW-1:0] tcnt;
  bus_kind_e     cur_kind;
  logic          cur_last;
  logic          low_done;

  assign idle     = (phase == PH_IDLE);
  assign low_done = (phase == PH_LOW) && (tcnt == '0);
  assign wr_rise  = low_done && (cur_kind != K_STAT);
  assign adl_arm  = wr_rise && (cur_kind == K_ADDR) && cur_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      tcnt        <= '0;
      cur_kind    <= K_CMD;
      cur_last    <= 1'b0;
      wr_strobe_n <= 1'b1;
      rd_strobe_n <= 1'b1;
      cmd_latch   <= 1'b0;
      addr_latch  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (acc) begin
            phase      <= PH_LOW;
            tcnt       <= SW'(STB_LO - 1);
            cur_kind   <= acc_kind;
            cur_last   <= acc_last;
            cmd_latch  <= (acc_kind == K_CMD);
            addr_latch <= (acc_kind == K_ADDR);
            if (acc_kind == K_STAT) rd_strobe_n <= 1'b0;
            else                    wr_strobe_n <= 1'b0;
          end
        end
        PH_LOW: begin
          if (tcnt == '0) begin
            wr_strobe_n <= 1'b1;
            rd_strobe_n <= 1'b1;
            phase       <= PH_HIGH;
            tcnt        <= SW'(STB_HI - 1);
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (tcnt == '0) begin
            phase      <= PH_IDLE;
            cmd_latch  <= 1'b0;
            addr_latch <= 1'b0;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_gap_guard.sv
module nand_gap_guard
  import nand_gap_pkg::*;
#(
  parameter int CLK_PS     = 10000,
  parameter int CNT_W      = 10,
  parameter int STB_LO     = 2,
  parameter int STB_HI     = 2,
  parameter int MARGIN_RST = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic       req_last_addr,
  input  logic [1:0] mode_sel,
  input  logic [3:0] margin,
  output logic       wr_strobe_n,
  output logic       rd_strobe_n,
  output logic       cmd_latch,
  output logic       addr_latch,
  output logic [1:0] stall_code
);

  localparam logic [CNT_W-1:0] LO_PLUS1 = CNT_W'(STB_LO + 1);

  bus_kind_e           kind;
  logic                idle, wr_rise, adl_arm, acc;
  logic                adl_busy, whr_busy, adl_hold, whr_hold;
  logic [MODE_W-1:0]   mode_q;
  logic [MARGIN_W-1:0] margin_q;
  logic [CNT_W-1:0]    adl_cyc, whr_cyc, adl_load, whr_load;

  assign kind = bus_kind_e'(req_kind);

  // mode and margin follow the inputs only while no cycle is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      margin_q <= MARGIN_W'(MARGIN_RST);
    end else if (idle) begin
      mode_q   <= mode_sel;
      margin_q <= margin;
    end
  end

  nand_gap_limits #(.CLK_PS(CLK_PS), .CNT_W(CNT_W)) u_limits (
    .mode    (mode_q),
    .mrg     (margin_q),
    .adl_cyc (adl_cyc),
    .whr_cyc (whr_cyc)
  );

  // counters are biased so the grant lands exactly on the limit
  assign adl_load = (adl_cyc >= LO_PLUS1) ? (adl_cyc - LO_PLUS1) : '0;
  assign whr_load = (whr_cyc != '0) ? (whr_cyc - 1'b1) : '0;

  nand_gap_timer #(.CNT_W(CNT_W)) u_adl_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (adl_arm),
    .load_val (adl_load),
    .clr      (acc && (kind == K_CMD || kind == K_ADDR)),
    .busy     (adl_busy)
  );

  nand_gap_timer #(.CNT_W(CNT_W)) u_whr_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_rise),
    .load_val (whr_load),
    .clr      (1'b0),
    .busy     (whr_busy)
  );

  assign adl_hold  = (kind == K_DIN)  && adl_busy;
  assign whr_hold  = (kind == K_STAT) && whr_busy;
  assign req_ready = idle && !adl_hold && !whr_hold;
  assign acc       = req_valid && req_ready;

  always_comb begin
    stall_code = 2'd0;
    if (req_valid && idle) begin
      if (adl_hold)      stall_code = 2'd1;
      else if (whr_hold) stall_code = 2'd2;
    end
  end

  nand_strobe_seq #(.STB_LO(STB_LO), .STB_HI(STB_HI)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .acc_kind    (kind),
    .acc_last    (req_last_addr),
    .idle        (idle),
    .wr_rise     (wr_rise),
    .adl_arm     (adl_arm),
    .wr_strobe_n (wr_strobe_n),
    .rd_strobe_n (rd_strobe_n),
    .cmd_latch   (cmd_latch),
    .addr_latch  (addr_latch)
  );

endmodule

// File: rtl/nand_gap_guard_chk.sv
module nand_gap_guard_chk
  import nand_gap_pkg::*;
#(
  parameter int CLK_PS = 10000
) (
  input logic                clk,
  input logic                rst,
  input logic                req_ready,
  input logic [1:0]          stall_code,
  input logic                wr_strobe_n,
  input logic                rd_strobe_n,
  input logic                cmd_latch,
  input logic                addr_latch,
  input logic [MODE_W-1:0]   mode_q,
  input logic [MARGIN_W-1:0] margin_q
);

  logic        wr_d;
  logic [15:0] since_rise;
  int          nw_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d       <= 1'b1;
      since_rise <= '1;
      nw_cap     <= 0;
    end else begin
      wr_d <= wr_strobe_n;
      if (wr_strobe_n && !wr_d) begin
        since_rise <= 16'd1;
        nw_cap     <= to_cycles(whr_min_ns(int'(mode_q)), int'(margin_q), CLK_PS);
      end else if (since_rise != '1) begin
        since_rise <= since_rise + 16'd1;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!wr_strobe_n && !rd_strobe_n)); // R3

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (wr_strobe_n && rd_strobe_n && !cmd_latch && !addr_latch)); // R3

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cmd_latch && addr_latch)); // R2

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (stall_code != 2'd0) |-> !req_ready); // R10

  AST_WHR_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe_n) |-> (int'(since_rise) >= nw_cap)); // R7

endmodule

bind nand_gap_guard nand_gap_guard_chk #(.CLK_PS(CLK_PS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .stall_code  (stall_code),
  .wr_strobe_n (wr_strobe_n),
  .rd_strobe_n (rd_strobe_n),
  .cmd_latch   (cmd_latch),
  .addr_latch  (addr_latch),
  .mode_q      (mode_q),
  .margin_q    (margin_q)
);

// File: tb/nand_gap_guard_tb.sv
module nand_gap_guard_tb;

  localparam int CLK_PS = 10000;
  localparam int LO     = 2;
  localparam int HI     = 2;
  localparam int NAT_WW = LO + HI + 1;
  localparam int NAT_WR = HI + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic       req_last_addr = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [3:0] margin = 4'd2;
  logic       wr_strobe_n, rd_strobe_n, cmd_latch, addr_latch;
  logic [1:0] stall_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nand_gap_guard #(.CLK_PS(CLK_PS), .STB_LO(LO), .STB_HI(HI)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_last_addr(req_last_addr), .mode_sel(mode_sel),
    .margin(margin), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .cmd_latch(cmd_latch), .addr_latch(addr_latch), .stall_code(stall_code)
  );

  // edge timestamps in cycles, taken at falling clock edges
  int  cyc = 0;
  int  wr_rise_t = 0, wr_rise_prev = 0, wr_fall_t = 0, wr_low_w = 0;
  int  rd_fall_t = 0, rd_ref_t = 0, rd_low_w = 0;
  logic wr_p = 1'b1, rd_p = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (wr_p && !wr_strobe_n) wr_fall_t = cyc;
    if (!wr_p && wr_strobe_n) begin
      wr_rise_prev = wr_rise_t;
      wr_rise_t    = cyc;
      wr_low_w     = cyc - wr_fall_t;
    end
    if (rd_p && !rd_strobe_n) begin
      rd_fall_t = cyc;
      rd_ref_t  = wr_rise_t;
    end
    if (!rd_p && rd_strobe_n) rd_low_w = cyc - rd_fall_t;
    wr_p = wr_strobe_n;
    rd_p = rd_strobe_n;
  end

  function automatic int ceil_cyc(input int ns, input int m);
    return (ns * 1000 * (16 + m) + 16 * CLK_PS - 1) / (16 * CLK_PS);
  endfunction

  function automatic int n_adl(input int mode, input int m);
    int t;
    case (mode) 1: t = 150; 2: t = 100; default: t = 200; endcase
    return ceil_cyc(t, m);
  endfunction

  function automatic int n_whr(input int mode, input int m);
    int t;
    case (mode) 1: t = 60; 2: t = 80; default: t = 120; endcase
    return ceil_cyc(t, m);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one request; returns at the falling edge after acceptance
  task automatic issue(input logic [1:0] k, input bit last, output int code);
    req_kind      = k;
    req_last_addr = last;
    req_valid     = 1'b1;
    code          = 0;
    #1;
    while (!req_ready) begin
      code = int'(stall_code);
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (LO + HI + 3) @(negedge clk);
  endtask

  task automatic set_mode(input int mode, input int m);
    mode_sel = 2'(mode);
    margin   = 4'(m);
    @(negedge clk);
  endtask

  task automatic run_adl(input int mode, input int m, input string tag);
    int c, n;
    set_mode(mode, m);
    issue(2'd0, 0, c);
    issue(2'd1, 1, c);
    issue(2'd2, 0, c);
    wait_idle();
    n = n_adl(mode, m);
    check(wr_rise_t - wr_rise_prev == imax(n, NAT_WW), {tag, " R5 addr-to-data gap"},
          wr_rise_t - wr_rise_prev, imax(n, NAT_WW));
    check(c == ((n - LO > HI + 1) ? 1 : 0), {tag, " R10 stall code on data"},
          c, (n - LO > HI + 1) ? 1 : 0);
  endtask

  task automatic run_whr(input int mode, input int m, input logic [1:0] wk, input string tag);
    int c, n;
    set_mode(mode, m);
    issue(wk, (wk == 2'd1), c);
    issue(2'd3, 0, c);
    wait_idle();
    n = n_whr(mode, m);
    check(rd_fall_t - rd_ref_t == imax(n, NAT_WR), {tag, " R7 turnaround"},
          rd_fall_t - rd_ref_t, imax(n, NAT_WR));
    check(c == ((n > HI + 1) ? 2 : 0), {tag, " R10 stall code on read"},
          c, (n > HI + 1) ? 2 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(wr_strobe_n && rd_strobe_n, "R1 strobes idle", {wr_strobe_n, rd_strobe_n}, 3);
    check(!cmd_latch && !addr_latch, "R1 latches low", {cmd_latch, addr_latch}, 0);
    check(stall_code == 2'd0 && req_ready, "R1 ready, no stall", {req_ready, stall_code}, 4);

    // R2 command strobe shape and latch enables
    set_mode(0, 2);
    issue(2'd0, 0, c);
    check(!wr_strobe_n && cmd_latch && !addr_latch, "R2 command drives cmd_latch",
          {wr_strobe_n, cmd_latch, addr_latch}, 2);
    wait_idle();
    check(wr_low_w == LO, "R2 write strobe low width", wr_low_w, LO);
    issue(2'd1, 0, c);
    check(!wr_strobe_n && addr_latch && !cmd_latch, "R2 address drives addr_latch",
          {wr_strobe_n, cmd_latch, addr_latch}, 1);
    wait_idle();

    // R3 read strobe shape, one cycle in flight
    issue(2'd3, 0, c);
    check(!rd_strobe_n && wr_strobe_n && !req_ready, "R3 read strobe, not ready in flight",
          {rd_strobe_n, wr_strobe_n, req_ready}, 2);
    wait_idle();
    check(rd_low_w == LO, "R3 read strobe low width", rd_low_w, LO);

    // R8 back-to-back writes run at natural pace
    issue(2'd0, 0, c);
    issue(2'd0, 0, c);
    wait_idle();
    check(wr_rise_t - wr_rise_prev == NAT_WW, "R8 cmd after cmd", wr_rise_t - wr_rise_prev, NAT_WW);
    issue(2'd1, 1, c);
    issue(2'd1, 0, c);
    wait_idle();
    check(wr_rise_t - wr_rise_prev == NAT_WW && c == 0, "R8 addr after last addr",
          wr_rise_t - wr_rise_prev, NAT_WW);

    // R4 R5 R7 each mode at default margin, R11 mode 3
    for (int md = 0; md < 3; md++) begin
      run_adl(md, 2, "R4");
      run_whr(md, 2, 2'd2, "R4");
    end
    run_adl(3, 2, "R11");
    run_whr(3, 2, 2'd0, "R11");
    // margin extremes
    run_adl(2, 0, "R4 margin0");
    run_whr(2, 0, 2'd1, "R4 margin0");
    run_adl(0, 15, "R4 margin15");
    run_whr(0, 15, 2'd2, "R4 margin15");

    // R6 clear and arming rules
    set_mode(0, 2);
    issue(2'd1, 1, c);
    issue(2'd0, 0, c);
    issue(2'd2, 0, c);
    wait_idle();
    check(wr_rise_t - wr_rise_prev == NAT_WW && c == 0, "R6 command clears gap",
          wr_rise_t - wr_rise_prev, NAT_WW);
    issue(2'd1, 1, c);
    issue(2'd1, 0, c);
    issue(2'd2, 0, c);
    wait_idle();
    check(wr_rise_t - wr_rise_prev == NAT_WW && c == 0, "R6 plain address clears gap",
          wr_rise_t - wr_rise_prev, NAT_WW);
    issue(2'd1, 0, c);
    issue(2'd2, 0, c);
    wait_idle();
    check(wr_rise_t - wr_rise_prev == NAT_WW && c == 0, "R6 plain address does not arm",
          wr_rise_t - wr_rise_prev, NAT_WW);
    issue(2'd1, 1, c);
    issue(2'd3, 0, c);
    wait_idle();
    check(rd_fall_t - rd_ref_t == imax(n_whr(0, 2), NAT_WR) && c == 2,
          "R6 read not held by addr gap", rd_fall_t - rd_ref_t, imax(n_whr(0, 2), NAT_WR));

    // R9 mode change while busy does not affect the loaded limit
    set_mode(0, 2);
    issue(2'd2, 0, c);
    mode_sel = 2'd1;
    margin   = 4'd0;
    issue(2'd3, 0, c);
    wait_idle();
    check(rd_fall_t - rd_ref_t == imax(n_whr(0, 2), NAT_WR), "R9 limit kept after busy change",
          rd_fall_t - rd_ref_t, imax(n_whr(0, 2), NAT_WR));
    issue(2'd2, 0, c);
    issue(2'd3, 0, c);
    wait_idle();
    check(rd_fall_t - rd_ref_t == imax(n_whr(1, 0), NAT_WR), "R9 new mode taken when idle",
          rd_fall_t - rd_ref_t, imax(n_whr(1, 0), NAT_WR));

    // randomised mix of modes, margins and patterns
    for (int i = 0; i < 60; i++) begin
      int md, mg, pat;
      md  = int'($urandom % 4);
      mg  = int'($urandom % 16);
      pat = int'($urandom % 3);
      if (pat == 0) run_adl(md, mg, "rand");
      else if (pat == 1) run_whr(md, mg, 2'($urandom % 3), "rand");
      else begin
        set_mode(md, mg);
        issue(2'd1, 0, c);
        issue(2'd2, 0, c);
        wait_idle();
        check(wr_rise_t - wr_rise_prev == NAT_WW, "rand R6 unarmed data",
              wr_rise_t - wr_rise_prev, NAT_WW);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule